// File: doc/BRIEF.md
# Cascaded FIFO Depth Token Controller

This block coordinates a ring of identical FIFO slices so that together they behave as one queue whose depth is the sum of the slice depths. Each slice carries a write token and a read token. Only the slice that holds a token may accept the corresponding access. When a slice accesses its last physical word, it passes that token to the next slice in the ring with a one-cycle expansion pulse. Slice 0 is the designated first slice and owns both tokens after reset. The slice addresses and selects that the block produces steer an external storage array, which is not part of this block.

The block also forms the chain-level status flags by combining the per-slice flags. Writes are gated by the combined full flag and reads by the combined empty flag. With a single slice the tokens never move, both expansion pulses stay low, and a half-full flag is produced. With a chain, the half-full flag is held low.

Top module: `exp_chain`

## Requirements
- R1: While reset is low and after it is released, slice 0 holds both tokens, both addresses are 0, `empty_o` and `aempty_o` are 1, `full_o`, `afull_o` and `half_o` are 0, and all selects and pulses are 0.
- R2: Exactly one slice holds the write token and exactly one holds the read token at every clock. An accepted write raises only the write-token holder's bit of `wr_sel_o`, and an accepted read raises only the read-token holder's bit of `rd_sel_o`. `wr_addr_o` and `rd_addr_o` give the holder's current word address.
- R3: Writes fill a slice's words 0 to DEPTH-1 in order. During the cycle whose rising edge writes word DEPTH-1, that slice's bit of `wexp_o` is 1. At that edge the write token moves to the next slice, and the next write goes to word 0 of that slice.
- R4: Reads drain a slice's words 0 to DEPTH-1 in order. During the cycle whose edge reads word DEPTH-1, that slice's bit of `rexp_o` is 1, and the read token moves to the next slice at that edge.
- R5: The last slice passes both tokens back to slice 0, so the chain forms a ring.
- R6: `full_o` is 1 exactly when every slice holds DEPTH words. While it is 1, `wr_en_i` is ignored: no write select and no write pulse occur.
- R7: `empty_o` is 1 exactly when every slice holds no words. While it is 1, `rd_en_i` is ignored: no read select and no read pulse occur.
- R8: A write and a read in the same cycle are both accepted when the queue is neither full nor empty. The per-slice counts update accordingly.
- R9: `afull_o` is 1 exactly when every slice holds at least DEPTH-AF_OFFSET words.
- R10: `aempty_o` is 1 exactly when every slice holds at most AE_OFFSET words.
- R11: With NUM_SLICES = 1, the tokens stay in the slice, addresses wrap from DEPTH-1 to 0, and `wexp_o` and `rexp_o` stay 0. `half_o` is 1 when more than DEPTH/2 words are held. With NUM_SLICES > 1, `half_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by write and read sides |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| wr_sel_o | output | NUM_SLICES | One-hot write strobe per slice |
| rd_sel_o | output | NUM_SLICES | One-hot read strobe per slice |
| wr_addr_o | output | $clog2(DEPTH) | Word address in the write-token holder |
| rd_addr_o | output | $clog2(DEPTH) | Word address in the read-token holder |
| wexp_o | output | NUM_SLICES | Write token hand-off pulse per slice |
| rexp_o | output | NUM_SLICES | Read token hand-off pulse per slice |
| full_o | output | 1 | All slices full |
| empty_o | output | 1 | All slices empty |
| afull_o | output | 1 | All slices at or above the almost-full level |
| aempty_o | output | 1 | All slices at or below the almost-empty level |
| half_o | output | 1 | More than half full (single slice only) |

## Verification
The assertions assume that `rst_ni` is released synchronously. They also assume the ring has one fixed first slice, so token uniqueness is an invariant rather than something to recover. The enables may take any value in any cycle, including writes into a full queue and reads from an empty one; the block's own gating keeps the invariants. The stimulus changes the enables only at falling edges. It fills past full and drains past empty, then runs write-biased, read-biased and balanced pseudo-random phases, so the tokens circle the ring several times and the flag thresholds are crossed in both directions.

// File: rtl/exp_chain_pkg.sv
package exp_chain_pkg;
  typedef struct packed {
    logic full;
    logic empty;
    logic afull;
    logic aempty;
    logic half;
  } chain_flags_t;
endpackage

// File: rtl/exp_token_cell.sv
module exp_token_cell #(
  parameter int DEPTH   = 8,
  parameter bit CHAINED = 1'b1,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_i,
  input  logic          go_i,
  input  logic          exp_i,
  output logic          tok_o,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic          exp_o
);
  logic          tok_q;
  logic [AW-1:0] addr_q;
  logic          last;

  assign last   = (addr_q == AW'(DEPTH - 1));
  assign fire_o = tok_q & go_i;
  assign exp_o  = CHAINED & fire_o & last;
  assign tok_o  = tok_q;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q  <= first_i;
      addr_q <= '0;
    end else begin
      if (exp_i)      tok_q <= 1'b1;
      else if (exp_o) tok_q <= 1'b0;
      if (fire_o)     addr_q <= last ? '0 : addr_q + 1'b1;
    end
  end

  // address only moves on an accepted access (R2)
  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o |=> $stable(addr_o));
  // a slice without the token does not fire (R2)
  assert_fire_needs_tok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> tok_o);
endmodule

// File: rtl/exp_slice.sv
module exp_slice #(
  parameter int DEPTH   = 8,
  parameter bit CHAINED = 1'b1,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_i,
  input  logic          wr_go_i,
  input  logic          rd_go_i,
  input  logic          wexp_i,
  input  logic          rexp_i,
  output logic          wtok_o,
  output logic          rtok_o,
  output logic          wfire_o,
  output logic          rfire_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          wexp_o,
  output logic          rexp_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  exp_token_cell #(.DEPTH(DEPTH), .CHAINED(CHAINED)) u_wr (
    .clk_i, .rst_ni, .first_i, .go_i(wr_go_i), .exp_i(wexp_i),
    .tok_o(wtok_o), .fire_o(wfire_o), .addr_o(waddr_o), .exp_o(wexp_o));

  exp_token_cell #(.DEPTH(DEPTH), .CHAINED(CHAINED)) u_rd (
    .clk_i, .rst_ni, .first_i, .go_i(rd_go_i), .exp_i(rexp_i),
    .tok_o(rtok_o), .fire_o(rfire_o), .addr_o(raddr_o), .exp_o(rexp_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({wfire_o, rfire_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
  assign cnt_o = cnt_q;

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_no_rd_dry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !(rfire_o && !wfire_o));
endmodule

// File: rtl/exp_flags.sv
module exp_flags
  import exp_chain_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int DEPTH      = 8,
  parameter int AF_OFFSET  = 2,
  parameter int AE_OFFSET  = 2,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic [NUM_SLICES-1:0][CW-1:0] cnt_i,
  output chain_flags_t                  flags_o
);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_AF   = CW'(DEPTH - AF_OFFSET);
  localparam logic [CW-1:0] LVL_AE   = CW'(AE_OFFSET);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

  always_comb begin
    flags_o.full   = 1'b1;
    flags_o.empty  = 1'b1;
    flags_o.afull  = 1'b1;
    flags_o.aempty = 1'b1;
    for (int i = 0; i < NUM_SLICES; i++) begin
      flags_o.full   &= (cnt_i[i] == LVL_FULL);
      flags_o.empty  &= (cnt_i[i] == '0);
      flags_o.afull  &= (cnt_i[i] >= LVL_AF);
      flags_o.aempty &= (cnt_i[i] <= LVL_AE);
    end
  end

  // half-full only exists for a lone slice
  if (NUM_SLICES == 1) begin : g_half
    assign flags_o.half = (cnt_i[0] > LVL_HALF);
  end else begin : g_nohalf
    assign flags_o.half = 1'b0;
  end
endmodule

// File: rtl/exp_chain.sv
module exp_chain
  import exp_chain_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int DEPTH      = 8,
  parameter int AF_OFFSET  = 2,
  parameter int AE_OFFSET  = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam bit CHAINED   = (NUM_SLICES > 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  output logic [NUM_SLICES-1:0] wr_sel_o,
  output logic [NUM_SLICES-1:0] rd_sel_o,
  output logic [AW-1:0]         wr_addr_o,
  output logic [AW-1:0]         rd_addr_o,
  output logic [NUM_SLICES-1:0] wexp_o,
  output logic [NUM_SLICES-1:0] rexp_o,
  output logic                  full_o,
  output logic                  empty_o,
  output logic                  afull_o,
  output logic                  aempty_o,
  output logic                  half_o
);
  logic [NUM_SLICES-1:0]         wtok, rtok, wexp_in, rexp_in;
  logic [NUM_SLICES-1:0][AW-1:0] waddr, raddr;
  logic [NUM_SLICES-1:0][CW-1:0] cnt;
  chain_flags_t                  flags;
  logic                          wr_go, rd_go;

  assign wr_go = wr_en_i & ~flags.full;
  assign rd_go = rd_en_i & ~flags.empty;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = (i + NUM_SLICES - 1) % NUM_SLICES;
    if (CHAINED) begin : g_ring
      assign wexp_in[i] = wexp_o[PREV];
      assign rexp_in[i] = rexp_o[PREV];
    end else begin : g_solo
      assign wexp_in[i] = 1'b0;
      assign rexp_in[i] = 1'b0;
    end

    exp_slice #(.DEPTH(DEPTH), .CHAINED(CHAINED)) u_slice (
      .clk_i, .rst_ni,
      .first_i (i == 0),
      .wr_go_i (wr_go),
      .rd_go_i (rd_go),
      .wexp_i  (wexp_in[i]),
      .rexp_i  (rexp_in[i]),
      .wtok_o  (wtok[i]),
      .rtok_o  (rtok[i]),
      .wfire_o (wr_sel_o[i]),
      .rfire_o (rd_sel_o[i]),
      .waddr_o (waddr[i]),
      .raddr_o (raddr[i]),
      .wexp_o  (wexp_o[i]),
      .rexp_o  (rexp_o[i]),
      .cnt_o   (cnt[i]));

    if (CHAINED) begin : g_hand_chk
      localparam int NEXT = (i + 1) % NUM_SLICES;
      assert_whand_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wexp_o[i] |=> (wtok[NEXT] && !wtok[i]));
      assert_rhand_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rexp_o[i] |=> (rtok[NEXT] && !rtok[i]));
    end
  end

  always_comb begin
    wr_addr_o = '0;
    rd_addr_o = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      wr_addr_o |= wtok[i] ? waddr[i] : '0;
      rd_addr_o |= rtok[i] ? raddr[i] : '0;
    end
  end

  exp_flags #(.NUM_SLICES(NUM_SLICES), .DEPTH(DEPTH),
              .AF_OFFSET(AF_OFFSET), .AE_OFFSET(AE_OFFSET)) u_flags (
    .cnt_i(cnt), .flags_o(flags));

  assign full_o   = flags.full;
  assign empty_o  = flags.empty;
  assign afull_o  = flags.afull;
  assign aempty_o = flags.aempty;
  assign half_o   = flags.half;

  assert_wtok_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wtok) == 1);
  assert_rtok_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rtok) == 1);
  assert_sel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o) && $onehot0(rd_sel_o));
  assert_no_wr_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (wr_sel_o == '0 && wexp_o == '0));
  assert_no_rd_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_sel_o == '0 && rexp_o == '0));
  assert_full_empty_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/exp_chain_tb_top.sv
module exp_chain_tb_top;
  localparam int N  = 3;
  localparam int D  = 8;
  localparam int AF = 2;
  localparam int AE = 2;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] wr_sel, rd_sel, wexp, rexp;
  logic [AW-1:0] wr_addr, rd_addr;
  logic full, empty, afull, aempty, half;

  logic [0:0] s_wr_sel, s_rd_sel, s_wexp, s_rexp;
  logic [AW-1:0] s_wr_addr, s_rd_addr;
  logic s_full, s_empty, s_afull, s_aempty, s_half;

  exp_chain #(.NUM_SLICES(N), .DEPTH(D), .AF_OFFSET(AF), .AE_OFFSET(AE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wr_sel_o(wr_sel), .rd_sel_o(rd_sel), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .wexp_o(wexp), .rexp_o(rexp), .full_o(full), .empty_o(empty),
    .afull_o(afull), .aempty_o(aempty), .half_o(half));

  exp_chain #(.NUM_SLICES(1), .DEPTH(D), .AF_OFFSET(AF), .AE_OFFSET(AE)) dut_single_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wr_sel_o(s_wr_sel), .rd_sel_o(s_rd_sel), .wr_addr_o(s_wr_addr), .rd_addr_o(s_rd_addr),
    .wexp_o(s_wexp), .rexp_o(s_rexp), .full_o(s_full), .empty_o(s_empty),
    .afull_o(s_afull), .aempty_o(s_aempty), .half_o(s_half));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int w = 0, r = 0, sw = 0, sr = 0;
  int scnt [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // reference model: one cycle, inputs driven at negedge, checked before posedge
  task automatic step(input bit we, input bit re);
    int occ, ws, wa, rs, ra, ewsel, ersel, ewexp, erexp;
    bit wok, rok, efull, eempty, eaf, eae;
    int socc; bit swok, srok;
    @(negedge clk);
    wr_en = we; rd_en = re;
    #5;
    occ = w - r;
    wok = we && (occ < N * D);
    rok = re && (occ > 0);
    ws = (w / D) % N; wa = w % D;
    rs = (r / D) % N; ra = r % D;
    ewsel = wok ? (1 << ws) : 0;
    ersel = rok ? (1 << rs) : 0;
    ewexp = (wok && wa == D - 1) ? (1 << ws) : 0;
    erexp = (rok && ra == D - 1) ? (1 << rs) : 0;
    efull = 1; eempty = 1; eaf = 1; eae = 1;
    for (int i = 0; i < N; i++) begin
      efull  &= (scnt[i] == D);
      eempty &= (scnt[i] == 0);
      eaf    &= (scnt[i] >= D - AF);
      eae    &= (scnt[i] <= AE);
    end
    cmp("R2 wr_sel", int'(wr_sel), ewsel);
    cmp("R4 rd_sel", int'(rd_sel), ersel);
    cmp("R3 wexp", int'(wexp), ewexp);
    cmp("R4 rexp", int'(rexp), erexp);
    cmp("R3 wr_addr", int'(wr_addr), wa);
    cmp("R4 rd_addr", int'(rd_addr), ra);
    cmp("R6 full", int'(full), int'(efull));
    cmp("R7 empty", int'(empty), int'(eempty));
    cmp("R9 afull", int'(afull), int'(eaf));
    cmp("R10 aempty", int'(aempty), int'(eae));
    cmp("R11 half chained", int'(half), 0);
    // single-slice model
    socc = sw - sr;
    swok = we && (socc < D);
    srok = re && (socc > 0);
    cmp("R11 s_wr_sel", int'(s_wr_sel), int'(swok));
    cmp("R11 s_rd_sel", int'(s_rd_sel), int'(srok));
    cmp("R11 s_wr_addr", int'(s_wr_addr), sw % D);
    cmp("R11 s_rd_addr", int'(s_rd_addr), sr % D);
    cmp("R11 s_exp", int'({s_wexp, s_rexp}), 0);
    cmp("R11 s_half", int'(s_half), int'(socc > D / 2));
    cmp("R6 s_full", int'(s_full), int'(socc == D));
    cmp("R7 s_empty", int'(s_empty), int'(socc == 0));
    @(posedge clk);
    if (wok) begin scnt[ws]++; w++; end
    if (rok) begin scnt[rs]--; r++; end
    if (swok) sw++;
    if (srok) sr++;
  endtask

  initial begin
    int lfsr;
    bit we, re;
    for (int i = 0; i < N; i++) scnt[i] = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    #5;
    cmp("R1 wr_addr", int'(wr_addr), 0);
    cmp("R1 rd_addr", int'(rd_addr), 0);
    cmp("R1 empty", int'(empty), 1);
    cmp("R1 aempty", int'(aempty), 1);
    cmp("R1 full", int'(full), 0);
    cmp("R1 afull", int'(afull), 0);
    cmp("R1 half", int'(s_half), 0);
    cmp("R1 sel", int'({wr_sel, rd_sel, wexp, rexp}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first write lands in slice 0 word 0 (checked by model)
    // fill past full: R3, R5 handoff, R6 overflow
    repeat (N * D + 3) step(1'b1, 1'b0);
    // drain past empty: R4, R7 underflow
    repeat (N * D + 3) step(1'b0, 1'b1);
    // R5/R8: random phases, tokens circle the ring several times
    lfsr = 16'hACE1;
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 300; c++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
        case (ph)
          0:       begin we = (lfsr & 3) != 0; re = (lfsr[3:2] == 2'b00) || lfsr[4]; end
          1:       begin we = (lfsr & 3) == 0; re = (lfsr[3:2] != 2'b00); end
          default: begin we = lfsr[0]; re = lfsr[5]; end
        endcase
        step(we, re);
      end
    end
    // R8: simultaneous access from a mid level
    repeat (10) step(1'b1, 1'b0);
    repeat (40) step(1'b1, 1'b1);
    chk(w > 3 * N * D, "R5 ring laps", w, 3 * N * D);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    done = 1'b1;
    report;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report;
      $finish;
    end
  end
endmodule